// File: doc/BRIEF.md
# Software Interrupt Pending Store With Selectable Banking

This block keeps the pending state of sixteen software-raised interrupt IDs for each of eight targets. Up to eight senders raise interrupts at the same time. Each sender has its own strobe, its own ID and its own target mask, so several requests can land in the same cycle. A target asks for its next interrupt with an acknowledge request. One cycle later the block answers with the winning ID, and that entry is cleared at the same clock edge.

A mode bit selects how entries are banked. With `route_en` clear (legacy mode), every entry is kept per sender as well as per target. The same ID can then wait on one target up to eight times, and the answer carries the index of the sender that raised it. With `route_en` set (merged mode), requests for an ID merge per target no matter who sent them. The answer then carries only the ID.

Top module: `sgi_pend_store`

## Requirements
- R1: In merged mode, any number of requests for one ID to one target, including requests in the same cycle from different senders, leave a single pending instance: one acknowledge returns it and the next returns the spurious value.
- R2: In legacy mode, each sender keeps its own instance of an ID per target, so eight senders raising one ID for one target give eight separate acknowledges.
- R3: The answer is 13 bits wide. Bits [12:10] hold the sender index in legacy mode, bits [3:0] hold the ID, and bits [9:4] are 0 whenever an ID is returned.
- R4: In merged mode, bits [12:10] of every answer are 0.
- R5: If a request arrives after its ID was acknowledged, it becomes pending again and yields a second acknowledge.
- R6: The lowest pending ID wins. In legacy mode, among instances of the same ID the lowest sender index wins.
- R7: Acknowledging a target with nothing pending returns 1023 and changes no state.
- R8: When a set and an acknowledge clear hit the same entry in the same cycle, the entry stays pending.
- R9: `rsp_vld` is high exactly in the cycle after a cycle with `ack_req` high. The winning entry is gone from that edge on.
- R10: Reset empties every entry and holds `rsp_vld` low.
- R11: A set affects only the targets whose bit is set in that sender's mask. An acknowledge clears state only on the addressed target.
- R12: Entries raised in legacy mode stay pending after a switch to merged mode. The first merged acknowledge for that ID clears the instances from all senders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_en | input | 1 | 1 = merged banking, 0 = legacy per-sender banking |
| set_vld | input | 8 | Per-sender request strobe |
| set_id | input | 32 | Per-sender ID, 4 bits per sender (sender s at [4s+3:4s]) |
| set_tgt | input | 64 | Per-sender target mask, 8 bits per sender (sender s at [8s+7:8s]) |
| ack_req | input | 1 | Acknowledge request |
| ack_tgt | input | 3 | Target being acknowledged |
| rsp_vld | output | 1 | Answer valid, one cycle after ack_req |
| rsp_data | output | 13 | Sender [12:10], ID [3:0], or 1023 if nothing is pending |

## Verification
Two functions can fall in the same cycle: a new request and the acknowledge that clears the same entry. Several senders can also raise the same ID for one target at once. The bench drives both collisions on purpose, in both modes. One case has an acknowledge and a matching set in the same cycle. The other has simultaneous sets from different senders. A behavioural model keeps per-sender pending flags and is compared against the answer on every clock, so a lost set, or a merge that fails to collapse, shows up as an extra or a missing acknowledge.

// File: rtl/sgi_pend_pkg.sv
package sgi_pend_pkg;
    localparam int RSP_W   = 13;
    localparam int SRC_LSB = 10;
    localparam logic [RSP_W-1:0] SPURIOUS = 13'd1023;

    typedef struct packed {
        logic             vld;
        logic [RSP_W-1:0] data;
    } rsp_t;
endpackage

// File: rtl/sgi_tgt_bank.sv
module sgi_tgt_bank #(
    parameter int NUM_SRC = 8,
    parameter int NUM_ID  = 16,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int ID_W   = $clog2(NUM_ID),
    localparam int ENT    = NUM_SRC * NUM_ID
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    merged,
    input  logic [NUM_SRC-1:0]      set_hit,
    input  logic [NUM_SRC*ID_W-1:0] set_id,
    input  logic                    clr_en,
    input  logic [SRC_W-1:0]        clr_src,
    input  logic [ID_W-1:0]         clr_id,
    output logic [ENT-1:0]          pend_q
);
    typedef struct packed {
        logic [ENT-1:0] pend;
    } bank_t;

    bank_t st_d, st_q;
    int    set_idx [NUM_SRC];

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            set_idx[s] = (merged ? 0 : s) * NUM_ID + int'(set_id[s*ID_W +: ID_W]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            if (merged) begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    st_d.pend[s*NUM_ID + int'(clr_id)] = 1'b0;
                end
            end else begin
                st_d.pend[int'(clr_src)*NUM_ID + int'(clr_id)] = 1'b0;
            end
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            if (set_hit[s]) begin
                st_d.pend[set_idx[s]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;

    assert_legacy_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !merged && set_hit == '0)
        |=> !pend_q[int'($past(clr_src))*NUM_ID + int'($past(clr_id))]);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_hit[g] |=> pend_q[$past(set_idx[g])]);

        assert_merged_clear_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && merged && set_hit == '0)
            |=> !pend_q[g*NUM_ID + int'($past(clr_id))]);
    end
endmodule

// File: rtl/sgi_pick.sv
module sgi_pick #(
    parameter int NUM_SRC = 8,
    parameter int NUM_ID  = 16,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int ID_W   = $clog2(NUM_ID),
    localparam int ENT    = NUM_SRC * NUM_ID
) (
    input  logic [ENT-1:0]   pend,
    input  logic             merged,
    output logic             found,
    output logic [SRC_W-1:0] win_src,
    output logic [ID_W-1:0]  win_id
);
    // Scan from the top down so the last hit written is the lowest ID,
    // and inside one ID the lowest sender.
    always_comb begin
        found   = 1'b0;
        win_src = '0;
        win_id  = '0;
        for (int i = NUM_ID - 1; i >= 0; i--) begin
            for (int s = NUM_SRC - 1; s >= 0; s--) begin
                if (pend[s*NUM_ID + i]) begin
                    found   = 1'b1;
                    win_id  = ID_W'(i);
                    win_src = merged ? '0 : SRC_W'(s);
                end
            end
        end
    end
endmodule

// File: rtl/sgi_pend_store.sv
module sgi_pend_store
    import sgi_pend_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int NUM_SRC = 8,
    parameter int NUM_ID  = 16,
    localparam int TGT_W  = $clog2(NUM_TGT),
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int ID_W   = $clog2(NUM_ID),
    localparam int ENT    = NUM_SRC * NUM_ID
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       route_en,
    input  logic [NUM_SRC-1:0]         set_vld,
    input  logic [NUM_SRC*ID_W-1:0]    set_id,
    input  logic [NUM_SRC*NUM_TGT-1:0] set_tgt,
    input  logic                       ack_req,
    input  logic [TGT_W-1:0]           ack_tgt,
    output logic                       rsp_vld,
    output logic [RSP_W-1:0]           rsp_data
);
    logic [ENT-1:0]   pend_all [NUM_TGT];
    logic [ENT-1:0]   pend_sel;
    logic             found;
    logic [SRC_W-1:0] win_src;
    logic [ID_W-1:0]  win_id;
    rsp_t             rsp_d, rsp_q;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        logic [NUM_SRC-1:0] hit;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
            assign hit[s] = set_vld[s] & set_tgt[s*NUM_TGT + t];
        end
        sgi_tgt_bank #(.NUM_SRC(NUM_SRC), .NUM_ID(NUM_ID)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .merged  (route_en),
            .set_hit (hit),
            .set_id  (set_id),
            .clr_en  (ack_req && found && (ack_tgt == TGT_W'(t))),
            .clr_src (win_src),
            .clr_id  (win_id),
            .pend_q  (pend_all[t])
        );
    end

    assign pend_sel = pend_all[ack_tgt];

    sgi_pick #(.NUM_SRC(NUM_SRC), .NUM_ID(NUM_ID)) pick_i (
        .pend    (pend_sel),
        .merged  (route_en),
        .found   (found),
        .win_src (win_src),
        .win_id  (win_id)
    );

    always_comb begin
        rsp_d      = '0;
        rsp_d.vld  = ack_req;
        if (!ack_req) begin
            rsp_d.data = rsp_q.data;
        end else if (found) begin
            rsp_d.data[SRC_LSB +: SRC_W] = win_src;
            rsp_d.data[ID_W-1:0]         = win_id;
        end else begin
            rsp_d.data = SPURIOUS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld  = rsp_q.vld;
    assign rsp_data = rsp_q.data;

    assert_rsp_follows_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> rsp_vld);

    assert_no_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !rsp_vld);

    assert_merged_no_sender_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && route_en) |=> (rsp_data[SRC_LSB +: SRC_W] == '0));

    assert_field_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_data == SPURIOUS || rsp_data[SRC_LSB-1:ID_W] == '0));

    assert_empty_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && pend_sel == '0) |=> (rsp_data == SPURIOUS));
endmodule

// File: tb/sgi_pend_store_tb_top.sv
`timescale 1ns/1ps
module sgi_pend_store_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        route_en = 1'b0;
    logic [7:0]  set_vld = '0;
    logic [31:0] set_id = '0;
    logic [63:0] set_tgt = '0;
    logic        ack_req = 1'b0;
    logic [2:0]  ack_tgt = '0;
    logic        rsp_vld;
    logic [12:0] rsp_data;

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R10";
    bit    done = 0;

    always #2 clk = ~clk;

    sgi_pend_store dut_i (
        .clk(clk), .rst_n(rst_n), .route_en(route_en),
        .set_vld(set_vld), .set_id(set_id), .set_tgt(set_tgt),
        .ack_req(ack_req), .ack_tgt(ack_tgt),
        .rsp_vld(rsp_vld), .rsp_data(rsp_data)
    );

    // Behavioural model: one flag per (target, real sender, ID).
    bit        mp [0:7][0:7][0:15];
    bit        exp_vld;
    bit [12:0] exp_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mp[t, s, i]) mp[t][s][i] = 0;
            exp_vld = 0;
        end else begin
            exp_vld = ack_req;
            if (ack_req) begin
                int fid, fs;
                fid = -1; fs = 0;
                for (int i = 0; i < 16 && fid < 0; i++)
                    for (int s = 0; s < 8 && fid < 0; s++)
                        if (mp[ack_tgt][s][i]) begin fid = i; fs = s; end
                if (fid < 0) exp_data = 13'd1023;
                else begin
                    exp_data = '0;
                    exp_data[3:0] = 4'(fid);
                    if (!route_en) exp_data[12:10] = 3'(fs);
                    if (route_en)
                        for (int s = 0; s < 8; s++) mp[ack_tgt][s][fid] = 0;
                    else
                        mp[ack_tgt][fs][fid] = 0;
                end
            end
            for (int s = 0; s < 8; s++)
                if (set_vld[s])
                    for (int t = 0; t < 8; t++)
                        if (set_tgt[s*8+t]) mp[t][s][set_id[s*4 +: 4]] = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (rsp_vld !== exp_vld || (exp_vld && rsp_data !== exp_data)) begin
                n_err++;
                $display("FAIL %s: vld=%0b data=%0d expected vld=%0b data=%0d",
                         tag, rsp_vld, rsp_data, exp_vld, exp_data);
            end
        end
    end

    task automatic send(input int s, input int id, input logic [7:0] mask);
        set_vld[s] = 1'b1;
        set_id[s*4 +: 4] = 4'(id);
        set_tgt[s*8 +: 8] = mask;
    endtask

    task automatic tick();
        @(negedge clk);
        set_vld = '0; set_tgt = '0; set_id = '0; ack_req = 1'b0;
    endtask

    task automatic ack(input int t);
        ack_req = 1'b1; ack_tgt = 3'(t);
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: during reset the answer is idle
        n_chk++;
        if (rsp_vld !== 1'b0) begin
            n_err++; $display("FAIL R10: rsp_vld=%0b expected 0", rsp_vld);
        end
        rst_n = 1'b1;
        tick();
        // R7 / R10: every target empty after reset
        tag = "R7";
        for (int t = 0; t < 8; t++) ack(t);

        // R2, R3: legacy, eight senders raise ID 5 on target 2 at once
        tag = "R2_R3"; route_en = 1'b0;
        for (int s = 0; s < 8; s++) send(s, 5, 8'b0000_0100);
        tick();
        for (int k = 0; k < 9; k++) ack(2);

        // R6: lowest ID first, then lowest sender
        tag = "R6";
        send(4, 9, 8'h02); send(1, 9, 8'h02); send(6, 3, 8'h02);
        tick();
        for (int k = 0; k < 4; k++) ack(1);

        // R11: mask selects targets 0, 5, 7
        tag = "R11";
        send(2, 7, 8'b1010_0001);
        tick();
        ack(4); ack(0); ack(0); ack(7); ack(5); ack(5);

        // R1, R4: merged, two senders same ID same target same cycle
        tag = "R1_R4"; route_en = 1'b1;
        send(0, 5, 8'h10); send(3, 5, 8'h10);
        tick();
        ack(4); ack(4);

        // R5: re-raise after acknowledge
        tag = "R5";
        send(1, 2, 8'h08); tick();
        ack(3);
        send(2, 2, 8'h08); tick();
        ack(3); ack(3);

        // R8: set and clear of the same entry in one cycle, merged
        tag = "R8";
        send(1, 6, 8'h40); tick();
        send(5, 6, 8'h40); ack(6);
        ack(6); ack(6);
        // R8 in legacy mode, same sender
        route_en = 1'b0;
        send(3, 11, 8'h40); tick();
        send(3, 11, 8'h40); ack(6);
        ack(6); ack(6);

        // R9: back-to-back acknowledges with gaps
        tag = "R9";
        send(0, 1, 8'h01); send(0, 0, 8'h01); tick();
        ack(0); tick(); ack(0); ack(0); tick();

        // R12: legacy entries survive switch to merged and clear together
        tag = "R12";
        send(3, 1, 8'h01); send(5, 1, 8'h01); tick();
        route_en = 1'b1; tick();
        ack(0); ack(0);

        // R10: reset in mid-run discards pending state
        tag = "R10"; route_en = 1'b0;
        send(6, 4, 8'hFF); tick();
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1; tick();
        ack(0); ack(7);
        tick(); tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule